// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is a register-mapped timer. A counter counts up from zero, one step for each tick of a power-of-two prescaler. It returns to zero after it reaches a programmable terminal value and raises an overflow flag when it does. A single compare channel, once placed in software-compare mode, raises a channel flag on the step that brings the counter to a programmed absolute value. When the channel interrupt is enabled, it also drives an interrupt line.

Software writes 32-bit words to configure the timer. Writes take effect on the next clock edge, and reads return data combinationally from the presented address. Both flags are cleared by writing one to them. The channel flag can be cleared in either of two registers: the channel control register or a global status register that mirrors the flag. A read-only register reports the counter width chosen at build time, 16 or 32 bits.

Top module: `tick_timer`

## Requirements
- R1: The register at 0x04 reads with the counter width in bits in [23:16] and zero elsewhere (0x0020_0000 for a 32-bit counter). Writes to it have no effect.
- R2: Control register 0x10 bits [2:0] hold N. While counting is enabled, the counter steps once every 2^N clocks: one step per clock for N=0, one per four clocks for N=2.
- R3: Control bit 3 enables counting. While it is 0 the counter holds its value.
- R4: Terminal register 0x18 resets to all ones. A step taken while the counter equals the terminal value returns the counter to 0.
- R5: Control bit 7 is the overflow flag. It sets on the step that returns the counter to 0. Writing 1 to bit 7 clears it, and writing 0 leaves it unchanged.
- R6: Any write to counter register 0x14 sets the counter and the prescaler phase to 0.
- R7: Channel control register 0x20 holds a mode field in [5:2]; value 4 selects software compare. In that mode, the flag in bit 7 sets on the clock edge after a step brings the counter to the value in register 0x24.
- R8: irq_o is a registered output. In every cycle it equals the channel flag AND the interrupt enable in channel control bit 6.
- R9: Global status register 0x1C bit 0 reads as the channel flag. Writing 1 there, or to channel control bit 7, clears the flag.
- R10: With mode 0 the channel sets no flag, and a flag that is already pending stays set until it is cleared.
- R11: When a flag set and a write-one clear land on the same edge, the flag ends up set.
- R12: After reset, every register reads 0 except the parameter register (R1) and the terminal register (R4). Unmapped addresses read 0.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one word per cycle |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Channel interrupt |

## Verification
The bound checker checks the following on every cycle:
- the counter holds while counting is disabled;
- it steps by one, or wraps to zero and sets the overflow flag, on each tick;
- a counter write zeroes it;
- a compare match sets the channel flag;
- irq_o follows flag AND enable;
- a disabled channel never sets its flag;
- a set wins over a same-edge clear.

Only the bench scenarios can show the following:
- the exact counts under each prescale setting;
- the register read encodings;
- that the parameter register ignores writes;
- that each of the two clear paths works.

The collision scenario times a global-status clear onto the edge where the compare match lands, while a flag is already pending.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;
  localparam int unsigned PS_W   = 3;
  localparam int unsigned MODE_W = 4;

  localparam logic [REG_AW-1:0] OFS_PARAM = 8'h04;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_CNT   = 8'h14;
  localparam logic [REG_AW-1:0] OFS_TERM  = 8'h18;
  localparam logic [REG_AW-1:0] OFS_STAT  = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_CHCTL = 8'h20;
  localparam logic [REG_AW-1:0] OFS_CHVAL = 8'h24;

  localparam logic [MODE_W-1:0] MODE_OFF   = 4'h0;
  localparam logic [MODE_W-1:0] MODE_SWCMP = 4'h4;
endpackage

// File: rtl/tick_timer_presc.sv
module tick_timer_presc #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             sync_clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (2 ** SEL_W) - 1;

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] mask;

  assign mask   = ~({DIV_W{1'b1}} << sel_i);
  assign tick_o = run_i && ((phase_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (sync_clr_i || !run_i) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer_cnt.sv
module tick_timer_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] term_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             adv_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             adv_q;

  assign wrap_o = tick_i && !clr_i && (cnt_q == term_i);
  assign cnt_o  = cnt_q;
  assign adv_o  = adv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      adv_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      adv_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
      adv_q <= 1'b1;
    end else begin
      adv_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_timer_chan.sv
module tick_timer_chan
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic              cfg_ie_i,
  input  logic              val_we_i,
  input  logic [CNT_W-1:0]  val_wdata_i,
  input  logic              clr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              adv_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              ie_o,
  output logic [CNT_W-1:0]  val_o,
  output logic              flag_o,
  output logic              set_o,
  output logic              irq_o
);
  logic [MODE_W-1:0] mode_q;
  logic              ie_q, ie_d;
  logic [CNT_W-1:0]  val_q;
  logic              flag_q, flag_d;
  logic              irq_q;

  // a match only counts on the step that lands on the value
  assign set_o  = (mode_q == MODE_SWCMP) && adv_i && (cnt_i == val_q);
  assign flag_d = set_o || (flag_q && !clr_i);
  assign ie_d   = cfg_we_i ? cfg_ie_i : ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      ie_q   <= 1'b0;
      val_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        mode_q <= cfg_mode_i;
      end
      if (val_we_i) begin
        val_q <= val_wdata_i;
      end
      ie_q   <= ie_d;
      flag_q <= flag_d;
      irq_q  <= flag_d && ie_d;
    end
  end

  assign mode_o = mode_q;
  assign ie_o   = ie_q;
  assign val_o  = val_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [7:0] WIDTH_CODE = 8'(CNT_W);

  logic wr_ctrl, wr_cnt, wr_term, wr_stat, wr_chctl, wr_chval;
  assign wr_ctrl  = wr_en_i && (addr_i == OFS_CTRL);
  assign wr_cnt   = wr_en_i && (addr_i == OFS_CNT);
  assign wr_term  = wr_en_i && (addr_i == OFS_TERM);
  assign wr_stat  = wr_en_i && (addr_i == OFS_STAT);
  assign wr_chctl = wr_en_i && (addr_i == OFS_CHCTL);
  assign wr_chval = wr_en_i && (addr_i == OFS_CHVAL);

  logic [PS_W-1:0]  presc_q;
  logic             run_q;
  logic             ovf_q;
  logic [CNT_W-1:0] term_q;

  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             adv;
  logic             wrap;

  logic [MODE_W-1:0] ch_mode;
  logic              ch_ie;
  logic [CNT_W-1:0]  ch_val;
  logic              ch_flag;
  logic              ch_set;
  logic              ch_clr;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      run_q   <= 1'b0;
      ovf_q   <= 1'b0;
      term_q  <= '1;
    end else begin
      if (wr_ctrl) begin
        presc_q <= wdata_i[PS_W-1:0];
        run_q   <= wdata_i[3];
      end
      if (wr_term) begin
        term_q <= wdata_i[CNT_W-1:0];
      end
      ovf_q <= wrap || (ovf_q && !(wr_ctrl && wdata_i[7]));
    end
  end

  tick_timer_presc #(.SEL_W(PS_W)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .sync_clr_i (wr_cnt),
    .sel_i      (presc_q),
    .tick_o     (tick)
  );

  tick_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .clr_i  (wr_cnt),
    .term_i (term_q),
    .cnt_o  (cnt),
    .adv_o  (adv),
    .wrap_o (wrap)
  );

  assign ch_clr = (wr_chctl && wdata_i[7]) || (wr_stat && wdata_i[0]);

  tick_timer_chan #(.CNT_W(CNT_W)) u_chan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (wr_chctl),
    .cfg_mode_i  (wdata_i[5:2]),
    .cfg_ie_i    (wdata_i[6]),
    .val_we_i    (wr_chval),
    .val_wdata_i (wdata_i[CNT_W-1:0]),
    .clr_i       (ch_clr),
    .cnt_i       (cnt),
    .adv_i       (adv),
    .mode_o      (ch_mode),
    .ie_o        (ch_ie),
    .val_o       (ch_val),
    .flag_o      (ch_flag),
    .set_o       (ch_set),
    .irq_o       (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      OFS_PARAM: rdata_o = {8'h00, WIDTH_CODE, 16'h0000};
      OFS_CTRL:  rdata_o = {24'h0, ovf_q, 3'b000, run_q, presc_q};
      OFS_CNT:   rdata_o = 32'(cnt);
      OFS_TERM:  rdata_o = 32'(term_q);
      OFS_STAT:  rdata_o = {31'h0, ch_flag};
      OFS_CHCTL: rdata_o = {24'h0, ch_flag, ch_ie, ch_mode, 2'b00};
      OFS_CHVAL: rdata_o = 32'(ch_val);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              tick_i,
  input logic              cnt_we_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  term_i,
  input logic              ovf_i,
  input logic              adv_i,
  input logic [MODE_W-1:0] mode_i,
  input logic [CNT_W-1:0]  val_i,
  input logic              flag_i,
  input logic              ie_i,
  input logic              set_i,
  input logic              clr_i,
  input logic              irq_i
);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we_i) |=> $stable(cnt_i));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_we_i && cnt_i != term_i) |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_we_i && cnt_i == term_i) |=> (cnt_i == '0) && ovf_i);

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_i == '0);

  p_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SWCMP && adv_i && cnt_i == val_i) |=> flag_i);

  p_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == (flag_i && ie_i));

  p_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF && !flag_i) |=> !flag_i);

  p_setwins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> flag_i);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run_q),
  .tick_i   (tick),
  .cnt_we_i (wr_cnt),
  .cnt_i    (cnt),
  .term_i   (term_q),
  .ovf_i    (ovf_q),
  .adv_i    (adv),
  .mode_i   (ch_mode),
  .val_i    (ch_val),
  .flag_i   (ch_flag),
  .ie_i     (ch_ie),
  .set_i    (ch_set),
  .clr_i    (ch_clr),
  .irq_i    (irq_o)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = 32'h0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  tick_timer dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  typedef struct {
    logic [31:0] exp;
    bit          is_irq;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  sample_ev;

  // monitor: pops one expected item per sample event
  initial begin
    forever begin
      @(sample_ev);
      #1;
      if (sb_q.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'h0, irq_o} : rdata_o;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    addr_i  = a;
    wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk_i);
    addr_i    = a;
    it.exp    = e;
    it.is_irq = 1'b0;
    it.tag    = tag;
    sb_q.push_back(it);
    ->sample_ev;
  endtask

  task automatic irq_chk(input logic e, input string tag);
    item_t it;
    @(negedge clk_i);
    it.exp    = {31'h0, e};
    it.is_irq = 1'b1;
    it.tag    = tag;
    sb_q.push_back(it);
    ->sample_ev;
  endtask

  // runs the counter for r+2 active edges, then stops it
  task automatic run_for(input int r, input logic [2:0] n);
    wr(8'h10, {28'h0, 1'b1, n});
    repeat (r) @(negedge clk_i);
    wr(8'h10, 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    rd_chk(8'h10, 32'h0, "R12 ctrl reset");
    rd_chk(8'h14, 32'h0, "R12 cnt reset");
    rd_chk(8'h20, 32'h0, "R12 chctl reset");
    rd_chk(8'h1C, 32'h0, "R12 stat reset");
    rd_chk(8'h24, 32'h0, "R12 chval reset");
    rd_chk(8'h08, 32'h0, "R12 unmapped");
    irq_chk(1'b0, "R12 irq reset");
    rd_chk(8'h18, 32'hFFFF_FFFF, "R4 term reset");
    rd_chk(8'h04, 32'h0020_0000, "R1 param");
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk(8'h04, 32'h0020_0000, "R1 param write ignored");

    // R3: prescale set but counting disabled
    wr(8'h10, 32'h2);
    repeat (10) @(negedge clk_i);
    rd_chk(8'h14, 32'h0, "R3 stopped");

    // R2: divide by 4 for 40 edges
    run_for(38, 3'd2);
    rd_chk(8'h14, 32'd10, "R2 div4");
    repeat (5) @(negedge clk_i);
    rd_chk(8'h14, 32'd10, "R3 hold after stop");

    wr(8'h14, 32'h1234);
    rd_chk(8'h14, 32'h0, "R6 cnt write clears");

    run_for(18, 3'd0);
    rd_chk(8'h14, 32'd20, "R2 div1");

    // R4/R5: terminal 4, 7 steps -> 1,2,3,4,0,1,2
    wr(8'h14, 32'h0);
    wr(8'h18, 32'd4);
    run_for(5, 3'd0);
    rd_chk(8'h14, 32'd2, "R4 wrap count");
    rd_chk(8'h10, 32'h80, "R5 overflow set");
    wr(8'h10, 32'h0);
    rd_chk(8'h10, 32'h80, "R5 write zero keeps flag");
    wr(8'h10, 32'h80);
    rd_chk(8'h10, 32'h0, "R5 w1c");

    // R7: compare at 5 with enable
    wr(8'h18, 32'hFF);
    wr(8'h14, 32'h0);
    wr(8'h24, 32'd5);
    wr(8'h20, 32'h50);
    rd_chk(8'h20, 32'h50, "R7 armed, no flag");
    irq_chk(1'b0, "R8 irq idle");
    run_for(8, 3'd0);
    rd_chk(8'h20, 32'hD0, "R7 flag set");
    rd_chk(8'h1C, 32'h1, "R9 mirror");
    irq_chk(1'b1, "R8 irq raised");

    wr(8'h1C, 32'h1);
    rd_chk(8'h20, 32'h50, "R9 clear via status");
    rd_chk(8'h1C, 32'h0, "R9 status cleared");
    irq_chk(1'b0, "R8 irq dropped");

    wr(8'h14, 32'h0);
    run_for(8, 3'd0);
    rd_chk(8'h20, 32'hD0, "R7 flag again");
    wr(8'h20, 32'hD0);
    rd_chk(8'h20, 32'h50, "R9 clear via chctl");

    // R8: enable off
    wr(8'h20, 32'h10);
    wr(8'h14, 32'h0);
    run_for(8, 3'd0);
    rd_chk(8'h20, 32'h90, "R7 flag without enable");
    irq_chk(1'b0, "R8 no irq when disabled");

    // R10: mode off keeps pending flag, then sets nothing
    wr(8'h20, 32'h00);
    rd_chk(8'h20, 32'h80, "R10 pending kept");
    wr(8'h20, 32'h80);
    rd_chk(8'h20, 32'h00, "R10 cleared");
    wr(8'h14, 32'h0);
    run_for(8, 3'd0);
    rd_chk(8'h20, 32'h00, "R10 no flag when off");
    rd_chk(8'h1C, 32'h0, "R10 status clear");

    // R11: clear lands on the edge of a new match
    wr(8'h20, 32'h50);
    wr(8'h14, 32'h0);
    run_for(8, 3'd0);
    rd_chk(8'h20, 32'hD0, "R11 precondition");
    wr(8'h14, 32'h0);
    wr(8'h10, 32'h8);
    repeat (4) @(negedge clk_i);
    wr(8'h1C, 32'h1);
    wr(8'h10, 32'h0);
    rd_chk(8'h14, 32'd8, "R11 count");
    rd_chk(8'h20, 32'hD0, "R11 set wins");
    irq_chk(1'b1, "R11 irq held");
    wr(8'h1C, 32'h1);
    rd_chk(8'h1C, 32'h0, "R11 later clear");

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule